// File: doc/BRIEF.md
# Residue-Number Wavelet Analysis Channel

This block handles one modulus of a residue-number-system datapath for a single level of a one-dimensional discrete wavelet analysis. Each clock cycle it takes one residue sample and runs it through a 6-tap orthogonal filter pair. It returns a decimated low-band (approximation) residue stream and a decimated high-band (detail) residue stream. A complete RNS transform uses one instance per modulus, for example 127, 126 and 125. The conversion into residues and the reconstruction out of residues both sit outside the block.

There is only one set of six table-based modular multipliers. On even samples they apply the low-pass coefficients, and on odd samples they apply the high-pass coefficients. The high-pass coefficients are the low-pass ones mirrored, with alternating signs. Two modular adder trees sum the products, one tree per band. Each tree advances only on its own phase of the sample parity, so each runs at half the input rate.

Top module: `rns_dwt_channel`

## Requirements
- R1: While rst is high at a clock edge, that edge clears every register. After the edge, approx_valid and detail_valid are low and both result ports read 0. Samples from before the reset contribute nothing to any later result.
- R2: The first sample captured after reset is sample n = 0, and each later edge captures the next sample. For even n the block outputs an approximation residue equal to (sum over k = 0..5 of h[k]·x[n−k]) mod M. Here x at a negative index counts as 0, and the default h = {43, 103, 59, −17, −11, 5}.
- R3: For odd n the block outputs a detail residue equal to (sum over k of g[k]·x[n−k]) mod M, where g[k] = (−1)^k·h[5−k]. With the default h this gives g = {5, 11, −17, −59, 103, −43}.
- R4: The result for sample n is on the port with its strobe high during the cycle that follows the sixth clock edge after the edge that captured sample n.
- R5: In steady operation approx_valid is high on every second cycle and detail_valid is high on the cycles in between. The two strobes are never high together, and neither stays high for two cycles in a row.
- R6: A negative coefficient c acts as the residue M − (|c| mod M). Every product, partial sum and output lies in 0..M−1. This holds at full scale, with every input equal to M−1.
- R7: Input residues must be below M. A result depends only on the six most recent samples, so a single impulse shows up at the outputs for at most six samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_res | input | W | Input residue, 0..M−1 |
| approx_res | output | W | Low-band residue for even samples |
| approx_valid | output | 1 | High for one cycle when approx_res holds a new result |
| detail_res | output | W | High-band residue for odd samples |
| detail_valid | output | 1 | High for one cycle when detail_res holds a new result |

## Verification
The bench targets five cases.

- An impulse. A table entry or tap that is swapped shows up at once as a wrong coefficient value on one of the two bands.
- Runs of M−1. Without the single conditional subtraction, or with a negative coefficient stored as a plain value instead of M − |c|, the sums leave the range or wrap wrongly.
- Alternating extremes and random data. These catch a tree that picks up the wrong phase of the shared products, and the result for an odd sample then comes out with low-pass coefficients.
- Resets in the middle of a stream. A delay line or tree stage that is not cleared leaks old samples into the first results and breaks the even-first parity.
- The strobe checks, run on every cycle. They catch any extra or missing pipeline stage.

// File: rtl/rns_dwt_channel.sv
module rns_dwt_channel #(
  parameter int M = 127,
  parameter int W = $clog2(M),
  parameter int HC [6] = '{43, 103, 59, -17, -11, 5}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_res,
  output logic [W-1:0] approx_res,
  output logic         approx_valid,
  output logic [W-1:0] detail_res,
  output logic         detail_valid
);
  localparam int T  = 6;
  localparam int L1 = T / 2;
  localparam logic [W-1:0] MTOP = W'(M - 1);
  localparam logic [W:0]   MW   = (W+1)'(M);

  function automatic int to_res(input int c);
    int r;
    r = c % M;
    if (r < 0) r = r + M;
    return r;
  endfunction

  // mirrored high-pass coefficient: g[k] = (-1)^k * h[T-1-k]
  function automatic int hp_coef(input int k);
    return (k % 2 == 1) ? -HC[T-1-k] : HC[T-1-k];
  endfunction

  function automatic logic [W-1:0] mul_mod(input int x, input int c);
    return W'((x * to_res(c)) % M);
  endfunction

  function automatic logic [W-1:0] add_mod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= MW) s = s - MW;
    return s[W-1:0];
  endfunction

  // tap delay line and sample parity
  logic [W-1:0] xd [T];
  logic         xv, xpar;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < T; k++) xd[k] <= '0;
      xv   <= 1'b0;
      xpar <= 1'b0;
    end else begin
      xd[0] <= in_res;
      for (int k = 1; k < T; k++) xd[k] <= xd[k-1];
      xv   <= 1'b1;
      xpar <= xv ? ~xpar : 1'b0;
    end
  end

  // shared lookup multipliers, one per tap, low/high table picked by parity
  logic [W-1:0] prod [T];
  logic         pv, ppar;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv   <= 1'b0;
      ppar <= 1'b0;
    end else begin
      pv   <= xv;
      ppar <= xpar;
    end
  end

  for (genvar k = 0; k < T; k++) begin : g_tap
    logic [W-1:0] lo_tab [M];
    logic [W-1:0] hi_tab [M];
    logic [W-1:0] prod_q;

    for (genvar i = 0; i < M; i++) begin : g_ent
      assign lo_tab[i] = mul_mod(i, HC[k]);
      assign hi_tab[i] = mul_mod(i, hp_coef(k));
    end

    always_ff @(posedge clk) begin
      if (rst) prod_q <= '0;
      else     prod_q <= xpar ? hi_tab[xd[k]] : lo_tab[xd[k]];
    end

    assign prod[k] = prod_q;

    a_r6_prod_range: assert property (@(posedge clk) disable iff (rst) prod_q <= MTOP);
  end

  // two half-rate adder trees, band 0 on even phase, band 1 on odd phase
  logic [W-1:0] band_res [2];
  logic         band_vld [2];

  for (genvar b = 0; b < 2; b++) begin : g_band
    logic         en;
    logic [W-1:0] l1 [L1];
    logic [W-1:0] l2a, l2b, res_q;
    logic         v1, v2, vo;

    assign en = pv && (ppar == 1'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int j = 0; j < L1; j++) l1[j] <= '0;
        l2a   <= '0;
        l2b   <= '0;
        res_q <= '0;
        v1    <= 1'b0;
        v2    <= 1'b0;
        vo    <= 1'b0;
      end else begin
        vo <= 1'b0;
        if (en) begin
          for (int j = 0; j < L1; j++) l1[j] <= add_mod(prod[2*j], prod[2*j+1]);
          l2a   <= add_mod(l1[0], l1[1]);
          l2b   <= l1[2];
          res_q <= add_mod(l2a, l2b);
          v1    <= 1'b1;
          v2    <= v1;
          vo    <= v2;
        end
      end
    end

    assign band_res[b] = res_q;
    assign band_vld[b] = vo;

    a_r6_tree_range: assert property (@(posedge clk) disable iff (rst)
      (l1[0] <= MTOP) && (l1[1] <= MTOP) && (l1[2] <= MTOP) && (l2a <= MTOP));
  end

  assign approx_res   = band_res[0];
  assign approx_valid = band_vld[0];
  assign detail_res   = band_res[1];
  assign detail_valid = band_vld[1];

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!approx_valid && !detail_valid && approx_res == '0 && detail_res == '0));
  a_r6_approx_range: assert property (@(posedge clk) disable iff (rst) approx_res <= MTOP);
  a_r6_detail_range: assert property (@(posedge clk) disable iff (rst) detail_res <= MTOP);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst) !(approx_valid && detail_valid));
  a_r5_approx_pulse: assert property (@(posedge clk) disable iff (rst) approx_valid |=> !approx_valid);
  a_r5_detail_pulse: assert property (@(posedge clk) disable iff (rst) detail_valid |=> !detail_valid);
  a_r5_offset: assert property (@(posedge clk) disable iff (rst) approx_valid |=> detail_valid);
endmodule

// File: tb/rns_dwt_channel_tb.sv
module rns_dwt_channel_tb;
  localparam int M = 127;
  localparam int W = $clog2(M);
  localparam int HC [6] = '{43, 103, 59, -17, -11, 5};
  localparam int GC [6] = '{5, 11, -17, -59, 103, -43};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] in_res = '0;
  logic [W-1:0] approx_res, detail_res;
  logic         approx_valid, detail_valid;

  int total = 0;
  int bad   = 0;
  int xs [4096];

  always #5 clk = ~clk;

  rns_dwt_channel #(.M(M)) u_dut (
    .clk(clk), .rst(rst), .in_res(in_res),
    .approx_res(approx_res), .approx_valid(approx_valid),
    .detail_res(detail_res), .detail_valid(detail_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_val(input int n, input bit hp);
    int s;
    s = 0;
    for (int k = 0; k < 6; k++)
      if (n - k >= 0) s += (hp ? GC[k] : HC[k]) * xs[n-k];
    s = s % M;
    if (s < 0) s += M;
    return s;
  endfunction

  // mode 0 impulse, 1 all M-1, 2 random, 3 alternating extremes
  task automatic run_seq(input int len, input int mode);
    rst = 1'b1;
    in_res = '0;
    repeat (3) begin
      @(negedge clk);
      chk(!approx_valid && !detail_valid, "R1 strobes", int'(approx_valid) + int'(detail_valid), 0);
      chk(approx_res == '0 && detail_res == '0, "R1 data", int'(approx_res) + int'(detail_res), 0);
    end
    for (int i = 0; i < len + 8; i++) begin
      case (mode)
        0: xs[i] = (i == 0) ? 1 : 0;
        1: xs[i] = M - 1;
        2: xs[i] = int'($urandom % M);
        default: xs[i] = (i % 2 == 0) ? M - 1 : 0;
      endcase
    end
    rst = 1'b0;
    in_res = W'(xs[0]);
    for (int e = 0; e < len + 8; e++) begin
      bit ea, ed;
      @(negedge clk);
      ea = (e >= 6) && (e % 2 == 0);
      ed = (e >= 7) && (e % 2 == 1);
      chk(approx_valid == ea, "R4/R5 approx_valid timing", int'(approx_valid), int'(ea));
      chk(detail_valid == ed, "R4/R5 detail_valid timing", int'(detail_valid), int'(ed));
      if (approx_valid && ea)
        chk(int'(approx_res) == ref_val(e - 6, 1'b0), "R2 approx value (R6,R7)",
            int'(approx_res), ref_val(e - 6, 1'b0));
      if (detail_valid && ed)
        chk(int'(detail_res) == ref_val(e - 6, 1'b1), "R3 detail value (R6,R7)",
            int'(detail_res), ref_val(e - 6, 1'b1));
      in_res = W'(xs[e + 1]);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    run_seq(24, 0);
    run_seq(30, 1);
    run_seq(30, 3);
    run_seq(1500, 2);
    run_seq(17, 1);
    run_seq(600, 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule